// File: doc/BRIEF.md
# Parameter Block Checksum Sequencer

This block reads a run of bytes from an attached byte-wide memory and folds them into a 16-bit checksum. It then stores that checksum back into the same memory. A one-cycle start pulse latches a base address, a byte count and a result address. The sequencer then streams reads through a synchronous memory port with one cycle of read latency.

The checksum does not shift a polynomial bit by bit. Each update mixes two nibbles of `crc ^ value` back into the register. The values fed in are 16-bit big-endian words that begin at every byte offset of the even part of the count, so neighbouring words share a byte. An odd count adds one last update with the trailing byte padded by a zero low byte.

When the fold is complete, the high result byte is written first and the low byte second. A one-cycle done pulse follows. A typical setup covers bytes 0x00 to 0xF7 and stores the result at 0xFC and 0xFD.

Top module: `nvram_csum_engine`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd` and `mem_wr` are low and `crc` reads 0xFFFF.
- R2: One update of register c with 16-bit value v is defined as follows. Let p = c ^ v, a = p[3:0] and b = p[7:4] ^ a. The new value is (c >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12), kept to 16 bits. The register starts every run at 0xFFFF.
- R3: Let E be the count with bit 0 cleared. For each k in 0..E-1, one update is applied with value {m[base+k], m[base+k+1]}, in ascending k. Bytes base..base+E are read, which is E+1 reads.
- R4: When the count is odd, one further update is applied with value {m[base+E], 8'h00}. This holds for a count of 1, which reads one byte.
- R5: A count of zero issues no reads and stores 0xFFFF.
- R6: The result high byte is written to `result_addr` and then the low byte to `result_addr+1`, modulo 2^AW. No other memory byte is written.
- R7: `done` is high for exactly one cycle. It rises on the (N+4)th clock edge after the edge that accepts `start` when any byte is read (N = E), and on the 2nd edge for a zero count. `crc` keeps the final value while idle.
- R8: A `start` pulse seen while `busy` is high has no effect on the reads, the stored result or `crc`.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle, and both stay low while idle. Read addresses wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| base_addr | input | AW | First byte of the covered region |
| byte_cnt | input | AW+1 | Number of bytes covered |
| result_addr | input | AW | Address for the high result byte |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| crc | output | 16 | Current or final checksum |

## Verification
A sweep of every byte value with a count of one isolates the update function and the odd-tail padding from the word pairing. Sweeps of counts 0 through 11 over incrementing, all-zero, all-ones and scrambled memory contents separate three properties: overlapping-word order, the extra byte read beyond an even region, and the odd tail. Regions that cross the top of the address space show the wrap. The full-size default region exercises the long-count path. A run with a start pulse injected mid-run shows that the pulse changes neither the stored result, the read count nor the untouched memory.

// File: rtl/nvcs_pkg.sv
package nvcs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_READ  = 3'd1,
        PH_DRAIN = 3'd2,
        PH_WHI   = 3'd3,
        PH_WLO   = 3'd4
    } phase_t;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    // Nibble-mixing update of the checksum register.
    function automatic logic [15:0] csum_next(input logic [15:0] c, input logic [15:0] v);
        logic [15:0] p;
        logic [15:0] a;
        logic [15:0] b;
        p = c ^ v;
        a = {12'h000, p[3:0]};
        b = {12'h000, p[7:4]} ^ a;
        return (c >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
    endfunction

endpackage

// File: rtl/csum_step.sv
module csum_step (
    input  logic [15:0] crc_in,
    input  logic [15:0] word,
    output logic [15:0] crc_out
);
    always_comb begin
        crc_out = nvcs_pkg::csum_next(crc_in, word);
    end
endmodule

// File: rtl/csum_len_split.sv
module csum_len_split #(
    parameter int CW = 9
) (
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] even_cnt,
    output logic          odd
);
    always_comb begin
        even_cnt = {cnt[CW-1:1], 1'b0};
        odd      = cnt[0];
    end
endmodule

// File: rtl/nvram_csum_engine.sv
module nvram_csum_engine #(
    parameter int AW = 8,
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] byte_cnt,
    input  logic [AW-1:0] result_addr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [15:0]   crc
);
    import nvcs_pkg::*;

    typedef struct packed {
        phase_t        ph;
        logic [AW-1:0] base;
        logic [AW-1:0] res;
        logic [CW-1:0] last;
        logic          odd;
        logic [CW-1:0] idx;
        logic          rv;
        logic [CW-1:0] ridx;
        logic [7:0]    prev;
        logic [15:0]   crc;
        logic          done;
    } eng_t;

    eng_t st_d, st_q;

    logic [CW-1:0] even_cnt;
    logic          odd_cnt;
    logic [15:0]   pair_out;
    logic [15:0]   tail_in;
    logic [15:0]   tail_out;

    csum_len_split #(.CW(CW)) u_split (
        .cnt      (byte_cnt),
        .even_cnt (even_cnt),
        .odd      (odd_cnt)
    );

    // Overlapping word update: previous byte high, arriving byte low.
    csum_step u_pair (
        .crc_in  (st_q.crc),
        .word    ({st_q.prev, mem_rdata}),
        .crc_out (pair_out)
    );

    // Odd tail update, chained behind the pair update when both apply.
    assign tail_in = (st_q.ridx != '0) ? pair_out : st_q.crc;

    csum_step u_tail (
        .crc_in  (tail_in),
        .word    ({mem_rdata, 8'h00}),
        .crc_out (tail_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.rv   = 1'b0;

        if (st_q.rv) begin
            st_d.prev = mem_rdata;
            if (st_q.ridx != '0) begin
                st_d.crc = pair_out;
            end
            if (st_q.ridx == st_q.last && st_q.odd) begin
                st_d.crc = tail_out;
            end
        end

        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.base = base_addr;
                    st_d.res  = result_addr;
                    st_d.last = even_cnt;
                    st_d.odd  = odd_cnt;
                    st_d.idx  = '0;
                    st_d.crc  = CRC_SEED;
                    st_d.ph   = (even_cnt == '0 && !odd_cnt) ? PH_WHI : PH_READ;
                end
            end
            PH_READ: begin
                st_d.rv   = 1'b1;
                st_d.ridx = st_q.idx;
                if (st_q.idx == st_q.last) begin
                    st_d.ph = PH_DRAIN;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            PH_DRAIN: st_d.ph = PH_WHI;
            PH_WHI:   st_d.ph = PH_WLO;
            PH_WLO: begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
            st_q.crc  <= CRC_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mem_rd    = (st_q.ph == PH_READ);
        mem_wr    = (st_q.ph == PH_WHI) || (st_q.ph == PH_WLO);
        mem_wdata = (st_q.ph == PH_WHI) ? st_q.crc[15:8] : st_q.crc[7:0];
        unique case (st_q.ph)
            PH_READ: mem_addr = st_q.base + st_q.idx[AW-1:0];
            PH_WLO:  mem_addr = st_q.res + 1'b1;
            default: mem_addr = st_q.res;
        endcase
        busy = (st_q.ph != PH_IDLE);
        done = st_q.done;
        crc  = st_q.crc;
    end

endmodule

// File: rtl/csum_engine_chk.sv
module csum_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [15:0] crc
);
    // R9: one access kind per cycle
    p_one_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9: memory port quiet while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    // R7: done lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: checksum held while idle and not restarted
    p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(crc));

    // R6: completion follows a write cycle
    p_done_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_wr));

    // R7: leaving busy coincides with done
    p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind nvram_csum_engine csum_engine_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .crc    (crc)
);

// File: tb/nvram_csum_engine_bench.sv
module nvram_csum_engine_bench;
    localparam int AW = 8;
    localparam int CW = AW + 1;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [CW-1:0] byte_cnt = '0;
    logic [AW-1:0] result_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = 8'h00;
    logic          busy;
    logic          done;
    logic [15:0]   crc;

    logic [7:0] mem [MSZ];
    logic [7:0] shadow [MSZ];

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    nvram_csum_engine #(.AW(AW)) u_nvram_csum_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .base_addr   (base_addr),
        .byte_cnt    (byte_cnt),
        .result_addr (result_addr),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .done        (done),
        .crc         (crc)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] upd(input logic [15:0] c, input logic [15:0] v);
        logic [15:0] p, a, b;
        p = c ^ v;
        a = 16'(p & 16'h000F);
        b = 16'((p >> 4) & 16'h000F) ^ a;
        return 16'((c >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12));
    endfunction

    function automatic logic [15:0] ref_crc(input int b, input int n);
        logic [15:0] c;
        int e;
        c = 16'hFFFF;
        e = n & ~1;
        for (int k = 0; k < e; k++)
            c = upd(c, {mem[(b + k) % MSZ], mem[(b + k + 1) % MSZ]});
        if (n % 2 == 1)
            c = upd(c, {mem[(b + e) % MSZ], 8'h00});
        return c;
    endfunction

    task automatic run(input int b, input int n, input int r, input bit poke);
        logic [15:0] exp;
        int e, cyc, reads, exp_cyc, exp_reads, bad;
        bit hit;
        for (int i = 0; i < MSZ; i++) shadow[i] = mem[i];
        exp = ref_crc(b, n);
        e = n & ~1;
        exp_reads = (n == 0) ? 0 : e + 1;
        exp_cyc = (n == 0) ? 2 : e + 4;
        @(negedge clk);
        base_addr = AW'(b); byte_cnt = CW'(n); result_addr = AW'(r); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0; reads = 0;
        while (!done && cyc < 2000) begin
            if (mem_rd) reads++;
            if (poke && cyc == 1) begin
                base_addr = AW'(b + 7); byte_cnt = CW'(0); result_addr = 8'h40; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        check(cyc == exp_cyc, "R7", "done latency", cyc, exp_cyc);
        check(reads == exp_reads, (n == 0) ? "R5" : "R3", "read count", reads, exp_reads);
        check(crc == exp, (n % 2 == 1) ? "R4" : "R3", "crc port", crc, exp);
        check(mem[r % MSZ] == exp[15:8], "R6", "high byte", mem[r % MSZ], exp[15:8]);
        check(mem[(r + 1) % MSZ] == exp[7:0], "R6", "low byte", mem[(r + 1) % MSZ], exp[7:0]);
        shadow[r % MSZ] = exp[15:8];
        shadow[(r + 1) % MSZ] = exp[7:0];
        bad = 0;
        for (int i = 0; i < MSZ; i++) if (mem[i] !== shadow[i]) bad++;
        check(bad == 0, poke ? "R8" : "R6", "other bytes changed", bad, 0);
        @(posedge clk);
        @(negedge clk);
        check(!done, "R7", "done width", done, 0);
        check(crc == exp, "R7", "crc held", crc, exp);
        hit = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R7", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < MSZ; i++) mem[i] = 8'(i);
        repeat (3) @(negedge clk);
        // R1: reset values
        check(!busy && !done && !mem_rd && !mem_wr, "R1", "outputs in reset",
              {busy, done, mem_rd, mem_wr}, 0);
        check(crc == 16'hFFFF, "R1", "crc in reset", crc, 16'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && crc == 16'hFFFF, "R1", "idle after reset", crc, 16'hFFFF);

        // R2, R4: every byte value with count 1
        for (int v = 0; v < 256; v++) begin
            mem[8'h20] = 8'(v);
            run(8'h20, 1, 8'h90, 1'b0);
        end

        // R3, R4, R5: count sweeps over several fills
        for (int pat = 0; pat < 4; pat++) begin
            for (int i = 0; i < MSZ; i++) begin
                case (pat)
                    0: mem[i] = 8'(i);
                    1: mem[i] = 8'h00;
                    2: mem[i] = 8'hFF;
                    default: mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
                endcase
            end
            for (int n = 0; n < 12; n++) run(8'h10, n, 8'hA0, 1'b0);
            // R9: region wraps past the top address
            for (int n = 1; n < 10; n++) run(8'hFB, n, 8'h80, 1'b0);
        end

        // R8: start during a run is ignored
        for (int i = 0; i < MSZ; i++) mem[i] = 8'((i * 91 + 5));
        run(8'h30, 5, 8'hB0, 1'b1);
        run(8'h31, 8, 8'hB4, 1'b1);

        // R3, R6: default full region, result at 0xFC/0xFD
        run(8'h00, 248, 8'hFC, 1'b0);
        run(8'h00, 248, 8'hFC, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule